// File: doc/BRIEF.md
# Trimmed Real-Time Clock Counter

This block keeps wall-clock time from a 32768 Hz oscillator tick. A prescaler turns every HALF_DIV oscillator ticks into a half-second mark. A programmable rate then picks every 1st, 2nd, 4th or 8th mark to advance a 32-bit seconds counter.

Crystal error is corrected by a signed 23-bit trim value. The trim is sign-extended and summed into a 24-bit accumulator at each counter advance. When a positive trim wraps the accumulator past its top, that advance moves the counter by two. When a negative trim takes the accumulator below zero, that advance moves the counter by zero.

Software reaches the block over a byte-wide register port. Software preloads the counter, the accumulator and the trim in staging registers, and a self-clearing load bit commits all three at once. Multi-byte reads of the counter stay coherent through a snapshot. An optional interrupt flags each advance.

Top module: `rtc_trim_top`

## Requirements
- R1: `half_mark_o` pulses high for one cycle in the cycle of every HALF_DIV-th asserted `tick_i`, counting from reset. The default HALF_DIV of 16384 gives 0.5 s at 32768 Hz.
- R2: The control register at address 0x0 holds the rate in bits [3:2]. A free-running 3-bit counter counts half marks. The counter advances on a half mark when the low `rate` bits of that mark counter are all ones, so once every 2^rate marks. With no advance and no load, `cnt_o` holds.
- R3: At each advance the accumulator becomes (accumulator + sign-extended trim) mod 2^24. Reads of addresses 0x6..0x8 return the live accumulator, little-endian.
- R4: The size of an advance depends on the trim sign and on whether the sum of R3 wraps. With trim ≥ 0, the counter adds 1, or adds 2 when the sum wraps past 2^24. With trim < 0, the counter adds 1, or adds 0 when the unsigned sum produces no carry (a borrow). The counter wraps mod 2^32.
- R5: Writes to the staging addresses change no live state. These are counter 0x2..0x5, accumulator 0x6..0x8 and trim 0x9..0xB, each little-endian, with the trim's top byte using bits [6:0]. Writing 1 to control bit 0 copies all three staging values into the live registers at the following clock edge. An advance due in that cycle is dropped.
- R6: Control bit 0 reads 1 for exactly the one cycle after it was written 1, then reads 0 unless it is written again.
- R7: A read of address 0x2 returns the live counter bits [7:0] and captures counter bits [31:8]. Reads of 0x3..0x5 return the captured bytes.
- R8: Control bit 1 enables the interrupt. The flag (`irq_o`, status address 0x1 bit 0) sets on every advance that occurs while enabled. Writing 1 to status bit 0 clears the flag, and a set in the same cycle wins.
- R9: After reset the counter, the accumulator, the trim, the interrupt enable, the flag and the load bit are 0, and the rate is 1. The control register therefore reads 0x04.
- R10: Reads of 0x9..0xB return the live trim, with bit 7 of address 0xB reading 0. Unmapped addresses and reads without `rd_en_i` return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle oscillator tick, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| cnt_o | output | CNT_W | Live seconds counter |
| half_mark_o | output | 1 | Half-second time mark pulse |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions take for granted that HALF_DIV is at least 2, so two half marks can never fall in adjacent cycles. They also assume `tick_i` and the bus strobes are synchronous and glitch-free. The bench drives every input on the falling edge, so ticks, reads and writes are single-cycle synchronous pulses. It shrinks HALF_DIV to 4 so that many advances, wraps and rate changes fit in a short run.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_STAT     = 1;
  localparam int unsigned ADDR_CNT0     = 2;
  localparam int unsigned CTRL_LOAD_BIT = 0;
  localparam int unsigned CTRL_IEN_BIT  = 1;
  localparam int unsigned CTRL_RATE_LSB = 2;

  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_TWO  = 2'd2
  } adv_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned HALF_DIV = 16384,
  parameter int unsigned RATE_W   = 2,
  localparam int unsigned DIV_W   = $clog2(HALF_DIV),
  localparam int unsigned MARK_W  = (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              half_mark_o,
  output logic              step_o
);
  logic [DIV_W-1:0]  half_q;
  logic [MARK_W-1:0] mark_q;
  logic [MARK_W-1:0] mask;
  logic              wrap;

  assign wrap        = (half_q == DIV_W'(HALF_DIV - 1));
  assign half_mark_o = tick_i & wrap;
  assign mask        = ~({MARK_W{1'b1}} << rate_i);
  assign step_o      = half_mark_o & ((mark_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
      mark_q <= '0;
    end else begin
      if (tick_i) half_q <= wrap ? '0 : half_q + 1'b1;
      if (half_mark_o) mark_q <= mark_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_trim_acc.sv
module rtc_trim_acc
  import rtc_trim_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned TRIM_W = 23,
  localparam int unsigned EXT_W = ACC_W - TRIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  acc_ld_i,
  input  logic [TRIM_W-1:0] trim_ld_i,
  input  logic              step_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [TRIM_W-1:0] trim_o,
  output adv_e              adv_o
);
  logic [ACC_W-1:0]  acc_q;
  logic [TRIM_W-1:0] trim_q;
  logic [ACC_W:0]    sum;
  logic              carry;
  logic              neg;

  assign neg   = trim_q[TRIM_W-1];
  assign sum   = {1'b0, acc_q} + {1'b0, {EXT_W{neg}}, trim_q};
  assign carry = sum[ACC_W];

  // negative trim: no carry means the sum went below zero
  always_comb begin
    if (neg) adv_o = carry ? ADV_ONE : ADV_NONE;
    else     adv_o = carry ? ADV_TWO : ADV_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      trim_q <= '0;
    end else if (load_i) begin
      acc_q  <= acc_ld_i;
      trim_q <= trim_ld_i;
    end else if (step_i) begin
      acc_q  <= sum[ACC_W-1:0];
    end
  end

  assign acc_o  = acc_q;
  assign trim_o = trim_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_trim_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_ld_i,
  input  logic             step_i,
  input  adv_e             adv_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= cnt_ld_i;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(adv_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned TRIM_W = 23,
  parameter int unsigned RATE_W = 2,
  localparam int unsigned CNT_B     = (CNT_W + 7) / 8,
  localparam int unsigned ACC_B     = (ACC_W + 7) / 8,
  localparam int unsigned TRIM_B    = (TRIM_W + 7) / 8,
  localparam int unsigned ACC_BASE  = ADDR_CNT0 + CNT_B,
  localparam int unsigned TRIM_BASE = ACC_BASE + ACC_B,
  localparam int unsigned SNAP_W    = CNT_W - BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [ACC_W-1:0]    acc_i,
  input  logic [TRIM_W-1:0]   trim_i,
  input  logic                step_i,
  output logic                load_o,
  output logic [RATE_W-1:0]   rate_o,
  output logic                irq_o,
  output logic [CNT_W-1:0]    stage_cnt_o,
  output logic [ACC_W-1:0]    stage_acc_o,
  output logic [TRIM_W-1:0]   stage_trim_o,
  output logic [BYTE_W-1:0]   rdata_o
);
  logic [CNT_W-1:0]      stage_cnt_q;
  logic [ACC_W-1:0]      stage_acc_q;
  logic [TRIM_W-1:0]     stage_trim_q;
  logic [SNAP_W-1:0]     snap_q;
  logic                  load_q, ien_q, flag_q;
  logic [RATE_W-1:0]     rate_q;
  logic                  wr_ctrl, wr_stat, rd_low;
  logic [CNT_B*8-9:0]    snap_pad;
  logic [ACC_B*8-1:0]    acc_pad;
  logic [TRIM_B*8-1:0]   trim_pad;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(ADDR_STAT));
  assign rd_low  = rd_en_i && (addr_i == ADDR_W'(ADDR_CNT0));

  // staging: byte lanes, live state untouched until load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_cnt_q  <= '0;
      stage_acc_q  <= '0;
      stage_trim_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < CNT_W; i++)
        if (addr_i == ADDR_W'(ADDR_CNT0 + i / 8)) stage_cnt_q[i] <= wdata_i[i % 8];
      for (int i = 0; i < ACC_W; i++)
        if (addr_i == ADDR_W'(ACC_BASE + i / 8)) stage_acc_q[i] <= wdata_i[i % 8];
      for (int i = 0; i < TRIM_W; i++)
        if (addr_i == ADDR_W'(TRIM_BASE + i / 8)) stage_trim_q[i] <= wdata_i[i % 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      ien_q  <= 1'b0;
      rate_q <= RATE_W'(1);
      flag_q <= 1'b0;
      snap_q <= '0;
    end else begin
      load_q <= wr_ctrl & wdata_i[CTRL_LOAD_BIT];
      if (wr_ctrl) begin
        ien_q  <= wdata_i[CTRL_IEN_BIT];
        rate_q <= wdata_i[CTRL_RATE_LSB +: RATE_W];
      end
      flag_q <= (step_i & ien_q & ~load_q) | (flag_q & ~(wr_stat & wdata_i[0]));
      if (rd_low) snap_q <= cnt_i[CNT_W-1:BYTE_W];
    end
  end

  assign snap_pad = (CNT_B*8-8)'(snap_q);
  assign acc_pad  = (ACC_B*8)'(acc_i);
  assign trim_pad = (TRIM_B*8)'(trim_i);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o = BYTE_W'({rate_q, ien_q, load_q});
      if (addr_i == ADDR_W'(ADDR_STAT)) rdata_o = BYTE_W'(flag_q);
      if (addr_i == ADDR_W'(ADDR_CNT0)) rdata_o = cnt_i[BYTE_W-1:0];
      for (int b = 1; b < CNT_B; b++)
        if (addr_i == ADDR_W'(ADDR_CNT0 + b)) rdata_o = snap_pad[(b-1)*8 +: 8];
      for (int b = 0; b < ACC_B; b++)
        if (addr_i == ADDR_W'(ACC_BASE + b)) rdata_o = acc_pad[b*8 +: 8];
      for (int b = 0; b < TRIM_B; b++)
        if (addr_i == ADDR_W'(TRIM_BASE + b)) rdata_o = trim_pad[b*8 +: 8];
    end
  end

  assign load_o       = load_q;
  assign rate_o       = rate_q;
  assign irq_o        = flag_q;
  assign stage_cnt_o  = stage_cnt_q;
  assign stage_acc_o  = stage_acc_q;
  assign stage_trim_o = stage_trim_q;
endmodule

// File: rtl/rtc_trim_top.sv
module rtc_trim_top
  import rtc_trim_pkg::*;
#(
  parameter int unsigned HALF_DIV = 16384,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ACC_W    = 24,
  parameter int unsigned TRIM_W   = 23,
  parameter int unsigned RATE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              half_mark_o,
  output logic              irq_o
);
  logic              step, load_q;
  logic [RATE_W-1:0] rate;
  logic [ACC_W-1:0]  acc, stage_acc;
  logic [TRIM_W-1:0] trim_q, stage_trim;
  logic [CNT_W-1:0]  stage_cnt;
  adv_e              adv;

  rtc_prescaler #(.HALF_DIV(HALF_DIV), .RATE_W(RATE_W)) u_pre (
    .clk_i, .rst_ni, .tick_i, .rate_i(rate), .half_mark_o, .step_o(step)
  );

  rtc_trim_acc #(.ACC_W(ACC_W), .TRIM_W(TRIM_W)) u_acc (
    .clk_i, .rst_ni, .load_i(load_q), .acc_ld_i(stage_acc), .trim_ld_i(stage_trim),
    .step_i(step), .acc_o(acc), .trim_o(trim_q), .adv_o(adv)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load_q), .cnt_ld_i(stage_cnt), .step_i(step),
    .adv_i(adv), .cnt_o
  );

  rtc_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .TRIM_W(TRIM_W), .RATE_W(RATE_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_o), .acc_i(acc), .trim_i(trim_q), .step_i(step),
    .load_o(load_q), .rate_o(rate), .irq_o,
    .stage_cnt_o(stage_cnt), .stage_acc_o(stage_acc), .stage_trim_o(stage_trim),
    .rdata_o
  );
endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TRIM_W = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wd0_i,
  input logic              load_i,
  input logic              step_i,
  input logic [TRIM_W-1:0] trim_i,
  input logic [CNT_W-1:0]  stage_cnt_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              half_mark_i,
  input logic              irq_i
);
  logic ctrl_set, stat_clr;
  assign ctrl_set = wr_en_i && (addr_i == ADDR_W'(0)) && wd0_i;
  assign stat_clr = wr_en_i && (addr_i == ADDR_W'(1)) && wd0_i;

  AST_HALF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_mark_i |=> !half_mark_i); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_i)); // R2
  AST_ZERO_TRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && trim_i == '0) |=> cnt_i == $past(cnt_i) + CNT_W'(1)); // R4
  AST_ADV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> (cnt_i - $past(cnt_i)) <= CNT_W'(2)); // R4
  AST_LOAD_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(stage_cnt_i)); // R5
  AST_LOAD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !ctrl_set) |=> !load_i); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !step_i) |=> !irq_i); // R8
endmodule

bind rtc_trim_top rtc_trim_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wd0_i(wdata_i[0]),
  .load_i(load_q), .step_i(step), .trim_i(trim_q), .stage_cnt_i(stage_cnt),
  .cnt_i(cnt_o), .half_mark_i(half_mark_o), .irq_i(irq_o)
);

// File: tb/sim_rtc_trim_top.sv
module sim_rtc_trim_top;
  localparam int HALF_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] cnt;
  logic        half_mark, irq;

  always #4 clk = ~clk;

  rtc_trim_top #(.HALF_DIV(HALF_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cnt_o(cnt),
    .half_mark_o(half_mark), .irq_o(irq)
  );

  int checks = 0, bad = 0, tick_mode = 2;
  bit done = 1'b0;

  // reference model state
  int unsigned m_half = 0;
  bit [2:0]  m_marks = 0;
  bit [31:0] m_cnt = 0, m_scnt = 0, m_snap = 0;
  bit [23:0] m_acc = 0, m_sacc = 0;
  bit [22:0] m_trim = 0, m_strim = 0;
  bit [1:0]  m_rate = 2'd1;
  bit        m_ien = 0, m_flag = 0, m_load = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_read(bit [3:0] a);
    case (a)
      4'h0: return {4'b0, m_rate, m_ien, m_load};
      4'h1: return {7'b0, m_flag};
      4'h2: return m_cnt[7:0];
      4'h3: return m_snap[15:8];
      4'h4: return m_snap[23:16];
      4'h5: return m_snap[31:24];
      4'h6: return m_acc[7:0];
      4'h7: return m_acc[15:8];
      4'h8: return m_acc[23:16];
      4'h9: return m_trim[7:0];
      4'hA: return m_trim[15:8];
      4'hB: return {1'b0, m_trim[22:16]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(bit [3:0] a);
    if (a == 0) return "R6";
    if (a == 1) return "R8";
    if (a >= 2 && a <= 5) return "R7";
    if (a >= 6 && a <= 8) return "R3";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit hm, st, carry, neg, clr;
      bit [2:0] mask;
      bit [24:0] sum;
      int adv;
      int unsigned n_half;
      bit [2:0] n_marks;
      bit [31:0] n_cnt, n_scnt, n_snap;
      bit [23:0] n_acc, n_sacc;
      bit [22:0] n_trim, n_strim;
      bit [1:0] n_rate;
      bit n_ien, n_flag, n_load;
      hm    = tick && (m_half == HALF_DIV - 1);
      mask  = 3'((1 << m_rate) - 1);
      st    = hm && ((m_marks & mask) == mask);
      sum   = {1'b0, m_acc} + {1'b0, m_trim[22], m_trim};
      carry = sum[24];
      neg   = m_trim[22];
      adv   = neg ? (carry ? 1 : 0) : (carry ? 2 : 1);
      n_half = tick ? (hm ? 0 : m_half + 1) : m_half;
      n_marks = hm ? m_marks + 3'd1 : m_marks;
      n_cnt = m_cnt; n_acc = m_acc; n_trim = m_trim;
      n_scnt = m_scnt; n_sacc = m_sacc; n_strim = m_strim; n_snap = m_snap;
      n_rate = m_rate; n_ien = m_ien; n_load = 1'b0;
      if (m_load) begin
        n_cnt = m_scnt; n_acc = m_sacc; n_trim = m_strim;
      end else if (st) begin
        n_cnt = m_cnt + 32'(adv); n_acc = sum[23:0];
      end
      clr = wr_en && addr == 4'h1 && wdata[0];
      n_flag = (st && m_ien && !m_load) || (m_flag && !clr);
      if (rd_en && addr == 4'h2) n_snap = m_cnt;
      if (wr_en) begin
        if (addr == 4'h0) begin
          n_load = wdata[0]; n_ien = wdata[1]; n_rate = wdata[3:2];
        end
        if (addr >= 4'h2 && addr <= 4'h5) n_scnt[(int'(addr) - 2) * 8 +: 8] = wdata;
        if (addr >= 4'h6 && addr <= 4'h8) n_sacc[(int'(addr) - 6) * 8 +: 8] = wdata;
        if (addr == 4'h9) n_strim[7:0] = wdata;
        if (addr == 4'hA) n_strim[15:8] = wdata;
        if (addr == 4'hB) n_strim[22:16] = wdata[6:0];
      end
      m_half = n_half; m_marks = n_marks; m_cnt = n_cnt; m_acc = n_acc; m_trim = n_trim;
      m_scnt = n_scnt; m_sacc = n_sacc; m_strim = n_strim; m_snap = n_snap;
      m_rate = n_rate; m_ien = n_ien; m_load = n_load; m_flag = n_flag;
    end
  end

  // compare every cycle, away from the edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit ehm;
      ehm = tick && (m_half == HALF_DIV - 1);
      chk(cnt === m_cnt, "R2 R4 cnt", cnt, m_cnt);
      chk(half_mark === ehm, "R1 half_mark", half_mark, ehm);
      chk(irq === m_flag, "R8 irq", irq, m_flag);
      chk(rdata === (rd_en ? m_read(addr) : 8'h00), rd_tag(addr), rdata,
          rd_en ? m_read(addr) : 8'h00);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tick = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [3:0] a, bit [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(bit [3:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_expect(bit [3:0] a, bit [7:0] exp, string tag);
    rd_en = 1'b1; addr = a;
    #2;
    chk(rdata === exp, tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd_expect(4'h0, 8'h04, "R9 ctrl");
    rd_expect(4'h1, 8'h00, "R9 stat");
    rd_expect(4'h2, 8'h00, "R9 cnt");
    rd_expect(4'h6, 8'h00, "R9 acc");
    rd_expect(4'h9, 8'h00, "R9 trim");
    chk(cnt === 32'h0, "R9 cnt_o", cnt, 0);
    // zero trim, rate 1
    tick_mode = 0;
    run(100);
    // R5 staging has no effect before load
    wr(4'h9, 8'hFF); wr(4'hA, 8'hFF); wr(4'hB, 8'hBF);
    rd_expect(4'h9, 8'h00, "R5 trim live");
    rd_expect(4'hB, 8'h00, "R5 trim live");
    // R6 load bit
    wr(4'h0, 8'h05);
    rd_expect(4'h0, 8'h05, "R6 load set");
    rd_expect(4'h0, 8'h04, "R6 load clear");
    rd_expect(4'hB, 8'h3F, "R10 trim top");
    run(200);
    rd(4'h6); rd(4'h7); rd(4'h8);
    // negative trim, borrows
    wr(4'h9, 8'h00); wr(4'hA, 8'h00); wr(4'hB, 8'h40);
    wr(4'h0, 8'h05);
    run(300);
    rd(4'h6); rd(4'h8);
    // counter wrap with accumulator near the top
    wr(4'h2, 8'hF0); wr(4'h3, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'hFF);
    wr(4'h6, 8'hF0); wr(4'h7, 8'hFF); wr(4'h8, 8'hFF);
    wr(4'h9, 8'h00); wr(4'hA, 8'h00); wr(4'hB, 8'h01);
    wr(4'h0, 8'h05);
    run(300);
    // rates
    wr(4'h0, 8'h00); run(100);
    wr(4'h0, 8'h08); run(200);
    wr(4'h0, 8'h0C); run(300);
    // interrupt
    wr(4'h0, 8'h06); run(60);
    rd(4'h1);
    wr(4'h1, 8'h01); run(40);
    tick_mode = 2; run(2);
    wr(4'h1, 8'h01);
    chk(irq === 1'b0, "R8 w1c", irq, 0);
    // R7 snapshot
    wr(4'h2, 8'h78); wr(4'h3, 8'h56); wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    wr(4'h0, 8'h05); run(1);
    rd_expect(4'h2, 8'h78, "R7 low");
    rd_expect(4'h3, 8'h56, "R7 snap1");
    rd_expect(4'h4, 8'h34, "R7 snap2");
    rd_expect(4'h5, 8'h12, "R7 snap3");
    rd_expect(4'hC, 8'h00, "R10 unmapped");
    tick_mode = 0;
    rd(4'h2); run(40); rd(4'h3); rd(4'h4); rd(4'h5);
    // random traffic
    tick_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) wr(4'($urandom_range(0, 12)), 8'($urandom));
      else if (op == 1) wr(4'h1, 8'h01);
      else if (op <= 4) rd(4'($urandom_range(0, 13)));
      else run(1);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule